// File: doc/BRIEF.md
# Host Serial Port Frame Engine

This block runs the synchronous serial link between a converter and a DSP host. Each frame moves one 16-bit word in each direction. As timing master it divides the system clock down to a bit clock. It counts a fixed number of bit clocks per frame and drives an active-low frame sync at the start of each frame. As timing slave it follows a bit clock and frame sync that the host supplies.

The transmit word from the converter side is loaded at the start of each frame and shifted out MSB first, changing on the rising bit-clock edge. Bits from the host are sampled on the falling edge. After the sixteenth bit is captured, the assembled word is presented together with a single-cycle strobe.

A second, delayed frame sync goes low in the bit slot that directly follows this device's word. A further identical device can use it as its own frame sync and take the next slot. The bit clock can run without pause, or it can be limited to a burst of 32 clocks after each frame sync.

Top module: `sfe_frame_engine`

## Requirements
- R1: In master mode with the clock-mode input high, `sclk_out` is a square wave of period DIV system clocks, high for DIV/2 and low for DIV/2, with its first rising edge DIV clocks after reset is released.
- R2: In master mode a frame is FRAME_BITS bit clocks long. `fs_n_out` goes low at the rising bit-clock edge that opens bit slot 0 and goes high again at the next rising edge, exactly once per frame.
- R3: `sdout` carries the transmit word MSB first in slots 0 to 15, and changes only with a rising bit-clock event. The word is captured at the frame-start event, and later changes of `tx_word` within the frame have no effect on `sdout`. Outside the 16 slots `sdout` is 0.
- R4: `sdin` is sampled at each falling bit-clock event of slots 0 to 15, MSB first. In the cycle after the sixteenth sample, `rx_word` holds the assembled word and `rx_valid` is 1 for exactly one cycle. `rx_word` then holds until the next complete word.
- R5: In master mode with the clock-mode input low, `sclk_out` pulses only during the first GATED_BITS slots of each frame and stays low for the rest of the frame. Frame length and sync timing are the same as in R2.
- R6: `chain_fs_n` is low exactly during bit slot 16, the slot after the last data bit, and high otherwise, in both modes.
- R7: In slave mode (`master_sel` = 0) the engine follows `sclk_in` and `fs_n_in` after a synchronizer delay of three system clocks. A rising edge seen while `fs_n_in` is low starts a frame. `sclk_out` is held at 0 and `fs_n_out` at 1.
- R8: While `rst` is high: `sclk_out` = 0, `fs_n_out` = 1, `sdout` = 0, `chain_fs_n` = 1, `rx_valid` = 0 and `rx_word` = 0.
- R9: In slave mode a frame sync that arrives before the current word is finished restarts the word. A new transmit word is loaded, and the aborted word produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1: generate bit clock and frame sync; 0: follow the host's |
| cont_clk | input | 1 | 1: continuous bit clock; 0: GATED_BITS clocks per frame (master) |
| sclk_in | input | 1 | Bit clock from the host (slave mode) |
| fs_n_in | input | 1 | Active-low frame sync from the host (slave mode) |
| sdin | input | 1 | Serial data from the host |
| tx_word | input | WORD_BITS | Word to send in the next frame |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| fs_n_out | output | 1 | Generated active-low frame sync (master mode) |
| sdout | output | 1 | Serial data to the host |
| chain_fs_n | output | 1 | Delayed active-low frame sync for the next chained device |
| rx_word | output | WORD_BITS | Last complete word received |
| rx_valid | output | 1 | One-cycle strobe on a new `rx_word` |

## Verification
Two events can land on the same rising bit-clock event. One is the frame start, which reloads the transmit shifter and resets the slot count. The other is the ordinary advance of a word still being shifted. In master mode this cannot happen, because the frame is longer than the word. In slave mode the bench provokes it by cutting a frame short after ten clocks and raising a new frame sync. It then checks that the new frame's word appears MSB first, and that the aborted word never raises `rx_valid`. The bench also changes `tx_word` in the middle of a word, on a cycle apart from the frame start, so that a reload outside the start event would show on `sdout`.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    // One bit-clock event, as seen by the word shifter.
    typedef struct packed {
        logic rise;   // rising bit-clock edge: advance the transmit side
        logic fall;   // falling bit-clock edge: sample the receive side
        logic start;  // this rise opens bit slot 0 of a new frame
        logic din;    // serial input bit, valid with fall
    } bit_evt_t;

    localparam bit_evt_t EVT_NONE = '{rise: 1'b0, fall: 1'b0, start: 1'b0, din: 1'b0};

    function automatic int unsigned half_period(input int unsigned div);
        return div / 2;
    endfunction

endpackage

// File: rtl/sfe_master_clkgen.sv
module sfe_master_clkgen
    import sfe_pkg::*;
#(
    parameter int unsigned DIV        = 18,
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned GATED_BITS = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cont_clk,
    input  logic     sdin,
    output logic     sclk,
    output logic     fs_n,
    output bit_evt_t evt
);
    localparam int unsigned HALF = half_period(DIV);
    localparam int unsigned DW   = $clog2(DIV);
    localparam int unsigned FW   = $clog2(FRAME_BITS);
    localparam logic [DW-1:0] D_LAST = DW'(DIV - 1);
    localparam logic [DW-1:0] D_MID  = DW'(HALF - 1);
    localparam logic [FW-1:0] F_LAST = FW'(FRAME_BITS - 1);

    logic [DW-1:0] dcnt;
    logic [FW-1:0] fcnt;
    logic [FW-1:0] fcnt_nx;
    logic          sclk_q;
    logic          fs_q;
    logic          gate_q;
    logic          rise_now;
    logic          fall_now;

    assign rise_now = (dcnt == D_LAST);
    assign fall_now = (dcnt == D_MID);
    assign fcnt_nx  = (fcnt == F_LAST) ? '0 : fcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt   <= '0;
            fcnt   <= F_LAST;
            sclk_q <= 1'b0;
            fs_q   <= 1'b1;
            gate_q <= 1'b0;
        end else begin
            dcnt <= rise_now ? '0 : dcnt + 1'b1;
            if (rise_now) begin
                sclk_q <= 1'b1;
                fcnt   <= fcnt_nx;
                fs_q   <= (fcnt_nx != '0);
                gate_q <= (int'(fcnt_nx) < int'(GATED_BITS));
            end else if (fall_now) begin
                sclk_q <= 1'b0;
            end
        end
    end

    assign sclk = sclk_q & (cont_clk | gate_q);
    assign fs_n = fs_q;

    always_comb begin
        evt       = EVT_NONE;
        evt.rise  = rise_now;
        evt.fall  = fall_now;
        evt.start = rise_now && (fcnt == F_LAST);
        evt.din   = sdin;
    end
endmodule

// File: rtl/sfe_slave_sync.sv
module sfe_slave_sync
    import sfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_in,
    input  logic     fs_n_in,
    input  logic     sdin,
    output bit_evt_t evt
);
    // bit order in the synchronizer: {bit clock, frame sync, data}
    localparam logic [2:0] IDLE_LVL = 3'b010;

    logic [2:0] stage1;
    logic [2:0] stage2;
    logic       sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1    <= IDLE_LVL;
            stage2    <= IDLE_LVL;
            sclk_prev <= 1'b0;
        end else begin
            stage1    <= {sclk_in, fs_n_in, sdin};
            stage2    <= stage1;
            sclk_prev <= stage2[2];
        end
    end

    always_comb begin
        evt       = EVT_NONE;
        evt.rise  = stage2[2] & ~sclk_prev;
        evt.fall  = ~stage2[2] & sclk_prev;
        evt.start = stage2[2] & ~sclk_prev & ~stage2[1];
        evt.din   = stage2[0];
    end
endmodule

// File: rtl/sfe_word_shifter.sv
module sfe_word_shifter
    import sfe_pkg::*;
#(
    parameter int unsigned WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bit_evt_t             evt,
    input  logic [WORD_BITS-1:0] tx_word,
    output logic                 sdout,
    output logic                 chain_fs_n,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_valid
);
    localparam int unsigned SW = $clog2(WORD_BITS + 2);
    localparam logic [SW-1:0] SLOT_LAST  = SW'(WORD_BITS - 1);
    localparam logic [SW-1:0] SLOT_CHAIN = SW'(WORD_BITS);
    localparam logic [SW-1:0] SLOT_IDLE  = SW'(WORD_BITS + 1);

    logic [SW-1:0]        slot;
    logic [WORD_BITS-1:0] tx_sh;
    logic [WORD_BITS-1:0] rx_sh;
    logic [WORD_BITS-1:0] rx_q;
    logic                 valid_q;
    logic                 in_word;
    logic [WORD_BITS-1:0] rx_nx;

    assign in_word = (slot < SLOT_CHAIN);
    assign rx_nx   = {rx_sh[WORD_BITS-2:0], evt.din};

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= SLOT_IDLE;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (evt.rise) begin
                if (evt.start) begin
                    slot  <= '0;
                    tx_sh <= tx_word;
                end else begin
                    if (slot != SLOT_IDLE) slot <= slot + 1'b1;
                    tx_sh <= {tx_sh[WORD_BITS-2:0], 1'b0};
                end
            end
            if (evt.fall && in_word) begin
                rx_sh <= rx_nx;
                if (slot == SLOT_LAST) begin
                    rx_q    <= rx_nx;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign sdout      = tx_sh[WORD_BITS-1] & in_word;
    assign chain_fs_n = (slot != SLOT_CHAIN);
    assign rx_word    = rx_q;
    assign rx_valid   = valid_q;
endmodule

// File: rtl/sfe_frame_engine.sv
module sfe_frame_engine
    import sfe_pkg::*;
#(
    parameter int unsigned DIV        = 18,
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned WORD_BITS  = 16,
    parameter int unsigned GATED_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 master_sel,
    input  logic                 cont_clk,
    input  logic                 sclk_in,
    input  logic                 fs_n_in,
    input  logic                 sdin,
    input  logic [WORD_BITS-1:0] tx_word,
    output logic                 sclk_out,
    output logic                 fs_n_out,
    output logic                 sdout,
    output logic                 chain_fs_n,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_valid
);
    bit_evt_t m_evt;
    bit_evt_t s_evt;
    bit_evt_t evt;
    logic     m_sclk;
    logic     m_fs_n;

    sfe_master_clkgen #(
        .DIV       (DIV),
        .FRAME_BITS(FRAME_BITS),
        .GATED_BITS(GATED_BITS)
    ) clkgen_i (
        .clk     (clk),
        .rst     (rst),
        .cont_clk(cont_clk),
        .sdin    (sdin),
        .sclk    (m_sclk),
        .fs_n    (m_fs_n),
        .evt     (m_evt)
    );

    sfe_slave_sync sync_i (
        .clk    (clk),
        .rst    (rst),
        .sclk_in(sclk_in),
        .fs_n_in(fs_n_in),
        .sdin   (sdin),
        .evt    (s_evt)
    );

    assign evt = master_sel ? m_evt : s_evt;

    sfe_word_shifter #(
        .WORD_BITS(WORD_BITS)
    ) shifter_i (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .tx_word   (tx_word),
        .sdout     (sdout),
        .chain_fs_n(chain_fs_n),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    assign sclk_out = master_sel & m_sclk;
    assign fs_n_out = ~master_sel | m_fs_n;
endmodule

// File: rtl/sfe_frame_checker.sv
module sfe_frame_checker #(
    parameter int unsigned DIV        = 18,
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned GATED_BITS = 32
) (
    input logic clk,
    input logic rst,
    input logic master_sel,
    input logic cont_clk,
    input logic sclk_out,
    input logic fs_n_out,
    input logic chain_fs_n,
    input logic rx_valid
);
    localparam int unsigned GW = $clog2(DIV) + 1;
    localparam int unsigned RW = $clog2(FRAME_BITS) + 1;

    logic [GW-1:0] gap;
    logic [RW-1:0] rises;
    logic          seen;
    logic          sclk_d;
    logic          fs_d;
    logic          rise_s;
    logic          fsfall_s;

    assign rise_s   = sclk_out & ~sclk_d;
    assign fsfall_s = ~fs_n_out & fs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            rises  <= '0;
            seen   <= 1'b0;
            sclk_d <= 1'b0;
            fs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_out;
            fs_d   <= fs_n_out;
            if (rise_s) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
            if (fsfall_s) rises <= RW'(1);
            else if (rise_s && rises != '1) rises <= rises + 1'b1;
        end
    end

    // R1
    clk_period_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel && cont_clk && seen && rise_s) |-> (gap == GW'(DIV - 1)));

    // R2
    fs_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel && fsfall_s) |-> rise_s);

    // R2
    fs_one_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel && rise_s && !fs_n_out) |-> fsfall_s);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R5
    gated_count_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel && !cont_clk && rise_s && fs_n_out) |-> (int'(rises) < int'(GATED_BITS)));

    // R6
    chain_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(chain_fs_n == 1'b0 && fs_n_out == 1'b0));

    // R7
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_sel |-> (!sclk_out && fs_n_out));
endmodule

bind sfe_frame_engine sfe_frame_checker #(
    .DIV       (DIV),
    .FRAME_BITS(FRAME_BITS),
    .GATED_BITS(GATED_BITS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .master_sel(master_sel),
    .cont_clk  (cont_clk),
    .sclk_out  (sclk_out),
    .fs_n_out  (fs_n_out),
    .chain_fs_n(chain_fs_n),
    .rx_valid  (rx_valid)
);

// File: tb/sfe_frame_engine_tb_top.sv
`timescale 1ns/1ps
module sfe_frame_engine_tb_top;
    localparam int DIV   = 6;
    localparam int HALF  = DIV / 2;
    localparam int FRAME = 40;
    localparam int W     = 16;
    localparam int GATED = 32;
    localparam int SH    = 5;   // half period of the host bit clock in slave runs

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         master_sel = 1'b1;
    logic         cont_clk = 1'b1;
    logic         sclk_in = 1'b0;
    logic         fs_n_in = 1'b1;
    logic         sdin = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         sclk_out, fs_n_out, sdout, chain_fs_n, rx_valid;
    logic [W-1:0] rx_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sfe_frame_engine #(
        .DIV(DIV), .FRAME_BITS(FRAME), .WORD_BITS(W), .GATED_BITS(GATED)
    ) dut_i (
        .clk(clk), .rst(rst), .master_sel(master_sel), .cont_clk(cont_clk),
        .sclk_in(sclk_in), .fs_n_in(fs_n_in), .sdin(sdin), .tx_word(tx_word),
        .sclk_out(sclk_out), .fs_n_out(fs_n_out), .sdout(sdout),
        .chain_fs_n(chain_fs_n), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lfsr(input logic [W-1:0] v);
        return {v[W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic apply_reset(input logic msel, input logic cont);
        rst = 1'b1;
        master_sel = msel;
        cont_clk = cont;
        sclk_in = 1'b0;
        fs_n_in = 1'b1;
        sdin = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(sclk_out == 1'b0, "R8", 32'(sclk_out), 0);
        chk(fs_n_out == 1'b1, "R8", 32'(fs_n_out), 1);
        chk(sdout == 1'b0, "R8", 32'(sdout), 0);
        chk(chain_fs_n == 1'b1, "R8", 32'(chain_fs_n), 1);
        chk(rx_valid == 1'b0, "R8", 32'(rx_valid), 0);
        chk(rx_word == '0, "R8", 32'(rx_word), 0);
        rst = 1'b0;
    endtask

    task automatic run_master(input logic cont, input int frames);
        logic [W-1:0] rx_pat  = 16'hFFFF;
        logic [W-1:0] lat_tx  = '0;
        logic [W-1:0] exp_rxw = '0;
        string clk_req = cont ? "R1" : "R5";
        tx_word = 16'h8001;
        apply_reset(1'b1, cont);
        for (int n = 1; n <= DIV * (FRAME * frames + 1); n++) begin
            int  p, cnt;
            bit  started;
            logic e_sclk, e_fs, e_sd, e_chain, e_val;
            @(negedge clk);
            started = (n >= DIV);
            p   = n % DIV;
            cnt = started ? ((n / DIV) - 1) % FRAME : FRAME - 1;
            if (started && p == 0 && cnt == 0) lat_tx = tx_word;
            e_sclk  = started && (p < HALF) && (cont || cnt < GATED);
            e_fs    = !(started && cnt == 0);
            e_sd    = (started && cnt < W) ? lat_tx[W-1-cnt] : 1'b0;
            e_chain = !(started && cnt == W);
            e_val   = started && (p == HALF) && (cnt == W - 1);
            if (e_val) exp_rxw = rx_pat;
            chk(sclk_out == e_sclk, clk_req, 32'(sclk_out), 32'(e_sclk));
            chk(fs_n_out == e_fs, "R2", 32'(fs_n_out), 32'(e_fs));
            chk(sdout == e_sd, "R3", 32'(sdout), 32'(e_sd));
            chk(chain_fs_n == e_chain, "R6", 32'(chain_fs_n), 32'(e_chain));
            chk(rx_valid == e_val, "R4", 32'(rx_valid), 32'(e_val));
            chk(rx_word == exp_rxw, "R4", 32'(rx_word), 32'(exp_rxw));
            // change the transmit word inside the word (must be ignored), receive pattern outside it
            if (started && p == 0 && cnt == 5) tx_word = lfsr(tx_word ^ 16'h00A5);
            if (started && p == 0 && cnt == 20) rx_pat = lfsr(rx_pat ^ 16'h3C00);
            sdin = (started && cnt < W) ? rx_pat[W-1-cnt] : 1'b0;
        end
    endtask

    task automatic slave_frame(input logic [W-1:0] tx, input logic [W-1:0] rx, input int nclk);
        tx_word = tx;
        fs_n_in = 1'b0;
        repeat (SH) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            int vcnt = 0;
            logic e_sd;
            sclk_in = 1'b1;
            sdin = (i < W) ? rx[W-1-i] : 1'b0;
            repeat (SH) @(negedge clk);
            if (i == 2) tx_word = ~tx;   // R9/R3: mid-word change has no effect
            e_sd = (i < W) ? tx[W-1-i] : 1'b0;
            chk(sdout == e_sd, "R3", 32'(sdout), 32'(e_sd));
            chk(chain_fs_n == (i != W), "R6", 32'(chain_fs_n), 32'(i != W));
            chk(sclk_out == 1'b0 && fs_n_out == 1'b1, "R7", {30'd0, sclk_out, fs_n_out}, 32'h1);
            sclk_in = 1'b0;
            if (i == 0) fs_n_in = 1'b1;
            for (int c = 0; c < SH; c++) begin
                @(negedge clk);
                if (rx_valid) vcnt++;
            end
            if (i == W - 1) begin
                chk(vcnt == 1, "R4", 32'(vcnt), 1);
                chk(rx_word == rx, "R4", 32'(rx_word), 32'(rx));
            end else begin
                chk(vcnt == 0, (nclk < W) ? "R9" : "R4", 32'(vcnt), 0);
            end
        end
    endtask

    initial begin
        run_master(1'b1, 3);
        run_master(1'b0, 3);
        apply_reset(1'b0, 1'b1);
        // R7: slave mode with host-driven clock and sync
        slave_frame(16'hA5C3, 16'h0F81, 20);
        slave_frame(16'h0001, 16'h8000, 18);
        // R9: a short frame aborted by a new frame sync
        slave_frame(16'h7E18, 16'h1234, 10);
        slave_frame(16'hC0DE, 16'hBEEF, 20);
        chk(rx_word == 16'hBEEF, "R9", 32'(rx_word), 32'hBEEF);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule